// File: doc/BRIEF.md
# Timer Capture/Compare Channel Unit

This block is a single channel of a general-purpose timer. It takes the value of a free-running 16-bit counter, a strobe that marks counter overflow, and one channel pin. It can do three jobs. In capture mode it copies the counter into its 16-bit channel value when a chosen edge appears on the pin. In compare mode it raises its flag and drives the pin when the counter reaches the channel value. In PWM mode it drives a pulse whose period is set by counter overflow and whose edge is set by the compare point.

Software reaches the block through a small byte-wide register port with three locations: an 8-bit status/control register, the channel value high byte, and the channel value low byte. The flag clears only through a read-then-write-zero handshake. A capture or compare event that arrives partway through that handshake cancels it, so an interrupt request is never lost. The interrupt line follows the flag, gated by an enable bit. The counter, the prescaler and channel pairing are outside this block.

Top module: `tcc_channel`

## Requirements
- R1: Reset is synchronous and active low. It sets the status/control register, the channel value and the pin output to 0, with the interrupt line and the pin enable low. Register addresses are 0 for status/control, 1 for the value high byte, 2 for the value low byte; address 3 reads 0.
- R2: The status/control bits, from bit 7 down to bit 0, are: flag, interrupt enable, mode B, mode A, level B, level A, overflow toggle, max duty. Bits 6..0 read back as written. Both value bytes read back as written.
- R3: Capture mode is mode B:A = 00. Level B:A picks the pin edge: 01 rising, 10 falling, 11 either, 00 none. A matching edge sets the flag and copies the counter into the channel value on the third rising clock edge after the pin change. The pin passes through two synchronizer flops before edge detection. A non-matching edge changes nothing.
- R4: Compare mode is mode B:A = 01. The flag sets on the first clock edge at which the counter equals the channel value. In that same edge the pin action runs: level B:A 01 toggles, 10 drives low, 11 drives high. A counter that stays equal gives no further event.
- R5: In compare mode with the overflow-toggle bit set, each overflow strobe toggles the pin. If an overflow strobe and a compare match come in the same cycle, only the compare action is applied.
- R6: PWM mode is mode B = 1. With level B:A = 10, overflow drives the pin high and a match drives it low. With 01 or 11 the levels are inverted. A match in the same cycle as an overflow wins, which gives 0 percent duty. A match also sets the flag.
- R7: In PWM mode the max-duty bit holds the pin at the overflow level from the next clock edge on, whatever the matches do. This is 100 percent duty.
- R8: Writing 0 to bit 7 clears the flag only if it follows a read of status/control that returned the flag as 1. A zero write with no such read leaves the flag set.
- R9: A capture or compare event between that read and the zero write, or in the same cycle as the write, leaves the flag set.
- R10: Writing 1 to bit 7 never sets the flag.
- R11: The interrupt line is high exactly when both the flag and the interrupt enable are 1.
- R12: In the variant built without mode bit B (parameter HAS_MSB = 0), bit 5 reads 0 and ignores writes.
- R13: The pin enable is high only when mode B:A is not 00 and level B:A is not 00. A compare-mode flag still sets when level B:A = 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| cnt_val | input | 16 | Free-running counter value |
| cnt_ovf | input | 1 | One-cycle counter overflow strobe |
| ch_pin_in | input | 1 | Channel pin input (asynchronous) |
| ch_pin_out | output | 1 | Channel pin output level |
| ch_pin_oe | output | 1 | Channel pin output enable |
| ch_irq | output | 1 | Interrupt request |

## Verification
A corrupted arm bit or flag shows up on the interrupt line in the cycle after the offending bus write: a cleared flag that should have stayed set, or one that still stands after a proper handshake. A wrong compare-history bit shows up as a missing or repeated flag one clock after the counter reaches the channel value. A wrong pin register shows up on the pin output at the same edge. A fault in the synchronizer or the edge select shows up three clocks after a pin change, either as a wrong interrupt or as a wrong captured value when the channel bytes are read back.

// File: rtl/tcc_pkg.sv
// Shared constants and types for the timer capture/compare channel.
// Assumes an 8-bit register port and a counter exactly two bytes wide.
package tcc_pkg;
    localparam int BUS_W = 8;
    localparam int CNT_W = 2 * BUS_W;

    localparam logic [1:0] ADR_SC  = 2'd0;
    localparam logic [1:0] ADR_VHI = 2'd1;
    localparam logic [1:0] ADR_VLO = 2'd2;

    // Status/control layout, bit 7 first.
    typedef struct packed {
        logic       flag;
        logic       ie;
        logic       msb;
        logic       msa;
        logic [1:0] els;
        logic       tov;
        logic       maxd;
    } sc_t;
endpackage

// File: rtl/tcc_pin_sync.sv
// Pin synchronizer and edge detector.
// Assumes pin_in is asynchronous; STAGES flops precede one history flop.
module tcc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_q;

    // Shift the pin through synchronizer stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[LAST-1:0], pin_in};
    end

    // Compare newest synchronized sample with the previous one.
    always_comb begin
        rise = sh_q[LAST-1] & ~sh_q[LAST];
        fall = ~sh_q[LAST-1] & sh_q[LAST];
    end
endmodule

// File: rtl/tcc_regs.sv
// Status/control and channel value registers with the guarded flag clear.
// Assumes a single-cycle bus strobe; a capture load beats a bus write.
module tcc_regs
    import tcc_pkg::*;
#(
    parameter bit HAS_MSB = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             evt,
    input  logic             cap_load,
    input  logic [CNT_W-1:0] cnt,
    output sc_t              sc,
    output logic [CNT_W-1:0] chval,
    output logic [BUS_W-1:0] rdata
);
    logic       flag_q, armed_q, ie_q, msa_q, msb_q, tov_q, maxd_q;
    logic [1:0] els_q;
    logic       wr_sc, rd_sc;

    assign wr_sc = wr_en && (addr == ADR_SC);
    assign rd_sc = rd_en && (addr == ADR_SC);

    // Plain control fields, written directly from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            msa_q  <= 1'b0;
            els_q  <= 2'b00;
            tov_q  <= 1'b0;
            maxd_q <= 1'b0;
        end else if (wr_sc) begin
            ie_q   <= wdata[6];
            msa_q  <= wdata[4];
            els_q  <= wdata[3:2];
            tov_q  <= wdata[1];
            maxd_q <= wdata[0];
        end
    end

    // Mode bit B exists only in the full variant.
    generate
        if (HAS_MSB) begin : g_msb
            // Hold mode bit B as written.
            always_ff @(posedge clk) begin
                if (!rst_n)     msb_q <= 1'b0;
                else if (wr_sc) msb_q <= wdata[5];
            end
        end else begin : g_no_msb
            assign msb_q = 1'b0;
        end
    endgenerate

    // Flag set by events, cleared only by an armed zero write.
    always_ff @(posedge clk) begin
        if (!rst_n)                             flag_q <= 1'b0;
        else if (evt)                           flag_q <= 1'b1;
        else if (wr_sc && !wdata[7] && armed_q) flag_q <= 1'b0;
    end

    // Arm on a read that sees the flag; any event or write disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)               armed_q <= 1'b0;
        else if (evt || wr_sc)    armed_q <= 1'b0;
        else if (rd_sc && flag_q) armed_q <= 1'b1;
    end

    // Channel value: capture load first, then byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                             chval <= '0;
        else if (cap_load)                      chval <= cnt;
        else if (wr_en && (addr == ADR_VHI))    chval[CNT_W-1:BUS_W] <= wdata;
        else if (wr_en && (addr == ADR_VLO))    chval[BUS_W-1:0] <= wdata;
    end

    assign sc = {flag_q, ie_q, msb_q, msa_q, els_q, tov_q, maxd_q};

    // Read mux selected by address.
    always_comb begin
        case (addr)
            ADR_SC:  rdata = sc;
            ADR_VHI: rdata = chval[CNT_W-1:BUS_W];
            ADR_VLO: rdata = chval[BUS_W-1:0];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tcc_action.sv
// Mode decode, capture/compare event generation and pin output register.
// Assumes cnt changes at most once per clock and ovf is a one-cycle strobe.
module tcc_action
    import tcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  sc_t              sc,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] chval,
    input  logic             ovf,
    input  logic             rise,
    input  logic             fall,
    output logic             evt,
    output logic             cap_load,
    output logic             pin_out,
    output logic             pin_oe
);
    logic is_cap, is_oc, is_pwm, linked;
    logic eq, eq_q, match, edge_hit, ovf_lvl;
    logic pin_q, pin_d;

    // Decode channel mode.
    always_comb begin
        is_cap  = !sc.msb && !sc.msa;
        is_oc   = !sc.msb && sc.msa;
        is_pwm  = sc.msb;
        linked  = (sc.els != 2'b00);
        ovf_lvl = (sc.els == 2'b10);
    end

    assign eq = (cnt == chval);

    // Remember last equality so a held counter matches only once.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end

    // Capture and compare events.
    always_comb begin
        match    = eq && !eq_q && !is_cap;
        edge_hit = is_cap && ((sc.els[0] && rise) || (sc.els[1] && fall));
        evt      = match || edge_hit;
        cap_load = edge_hit;
    end

    // Next pin level; compare action has priority over overflow.
    always_comb begin
        pin_d = pin_q;
        if (is_oc && linked) begin
            if (match) begin
                case (sc.els)
                    2'b01:   pin_d = ~pin_q;
                    2'b10:   pin_d = 1'b0;
                    default: pin_d = 1'b1;
                endcase
            end else if (ovf && sc.tov) begin
                pin_d = ~pin_q;
            end
        end else if (is_pwm && linked) begin
            if (sc.maxd)   pin_d = ovf_lvl;
            else if (match) pin_d = ~ovf_lvl;
            else if (ovf)   pin_d = ovf_lvl;
        end
    end

    // Pin output register.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign pin_out = pin_q;
    assign pin_oe  = !is_cap && linked;
endmodule

// File: rtl/tcc_channel.sv
// Top of one timer capture/compare channel.
// Assumes an external free-running counter and overflow strobe.
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_MSB     = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [15:0] cnt_val,
    input  logic        cnt_ovf,
    input  logic        ch_pin_in,
    output logic        ch_pin_out,
    output logic        ch_pin_oe,
    output logic        ch_irq
);
    sc_t              sc_q;
    logic [CNT_W-1:0] chval_q;
    logic             chan_evt, cap_load, edge_rise, edge_fall;

    tcc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(ch_pin_in),
        .rise(edge_rise), .fall(edge_fall)
    );

    tcc_regs #(.HAS_MSB(HAS_MSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .evt(chan_evt),
        .cap_load(cap_load), .cnt(cnt_val), .sc(sc_q),
        .chval(chval_q), .rdata(bus_rdata)
    );

    tcc_action u_act (
        .clk(clk), .rst_n(rst_n), .sc(sc_q), .cnt(cnt_val),
        .chval(chval_q), .ovf(cnt_ovf), .rise(edge_rise), .fall(edge_fall),
        .evt(chan_evt), .cap_load(cap_load),
        .pin_out(ch_pin_out), .pin_oe(ch_pin_oe)
    );

    assign ch_irq = sc_q.flag & sc_q.ie;
endmodule

// File: rtl/tcc_channel_chk.sv
// Temporal checks on the channel, attached to every tcc_channel by bind.
module tcc_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] sc,
    input logic       evt,
    input logic       pin_out,
    input logic       pin_oe
);
    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> sc[7]); // R9

    AST_FLAG_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc[7]) |-> $past(evt)); // R3

    AST_FLAG_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sc[7]) |-> $past(wr_en && addr == 2'd0 && !wdata[7] && !evt)); // R8

    AST_WRITE_ONE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && wdata[7] && !sc[7] && !evt) |=> !sc[7]); // R10

    AST_CAPTURE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sc[5] && !sc[4]) |-> !pin_oe); // R13

    AST_MAX_DUTY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (sc[5] && sc[0] && sc[3:2] != 2'b00 && $past(sc[5] && sc[0]) && $stable(sc[3:2]))
        |-> (pin_out == (sc[3:2] == 2'b10))); // R7
endmodule

bind tcc_channel tcc_channel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .sc(sc_q), .evt(chan_evt),
    .pin_out(ch_pin_out), .pin_oe(ch_pin_oe)
);

// File: tb/tcc_channel_tb.sv
module tcc_channel_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, ovf = 1'b0, pin_in = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'h00;
    logic [15:0] cnt = 16'hFFFF;
    logic [7:0]  rdata, rdata_v;
    logic        pin_out, pin_oe, irq, pin_out_v, pin_oe_v, irq_v;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tcc_channel u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_en), .bus_rd(rd_en),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .cnt_val(cnt), .cnt_ovf(ovf), .ch_pin_in(pin_in),
        .ch_pin_out(pin_out), .ch_pin_oe(pin_oe), .ch_irq(irq)
    );

    tcc_channel #(.HAS_MSB(1'b0)) u_var (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_en), .bus_rd(rd_en),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_v),
        .cnt_val(cnt), .cnt_ovf(ovf), .ch_pin_in(pin_in),
        .ch_pin_out(pin_out_v), .ch_pin_oe(pin_oe_v), .ch_irq(irq_v)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic [7:0] dv);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata; dv = rdata_v;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Full clear handshake: read status/control, then write it back with flag 0.
    task automatic clear_flag(input logic [7:0] sc_val);
        logic [7:0] d, dv;
        bus_rd(2'd0, d, dv);
        bus_wr(2'd0, sc_val & 8'h7F);
    endtask

    // One compare event: counter away for a cycle, then onto the value.
    task automatic hit_value(input logic [15:0] away, input logic [15:0] v);
        cnt = away; idle(1);
        cnt = v;    idle(1);
        cnt = away;
    endtask

    function automatic logic cap_hit(input logic [1:0] els, input logic rising);
        return (els[0] && rising) || (els[1] && !rising);
    endfunction

    function automatic logic oc_pin(input logic [1:0] els, input logic prev);
        case (els)
            2'b01:   return ~prev;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return prev;
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL WDOG actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d, dv;
        logic [15:0] exp_val, nv;
        logic        exp_pin, hit, rising;
        logic [1:0]  els;
        void'($urandom(32'h5EED_1234));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(2'd0, d, dv); chk("R1 sc", d, 8'h00);
        bus_rd(2'd1, d, dv); chk("R1 vhi", d, 8'h00);
        bus_rd(2'd2, d, dv); chk("R1 vlo", d, 8'h00);
        bus_rd(2'd3, d, dv); chk("R1 addr3", d, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 oe", pin_oe, 1'b0);

        // R2 / R10 / R12 readback of all control bits
        bus_wr(2'd0, 8'hFF);
        bus_rd(2'd0, d, dv);
        chk("R2 R10 sc readback", d, 8'h7F);
        chk("R12 variant bit5", dv, 8'h5F);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd1, 8'h12); bus_wr(2'd2, 8'h34);
        bus_rd(2'd1, d, dv); chk("R2 vhi", d, 8'h12);
        bus_rd(2'd2, d, dv); chk("R2 vlo", d, 8'h34);
        exp_val = 16'h1234;

        // R3 directed rising capture with latency
        cnt = 16'h0100;
        bus_wr(2'd0, 8'h44);
        chk("R13 capture oe", pin_oe, 1'b0);
        pin_in = 1'b1;
        idle(2); chk("R3 latency early", irq, 1'b0);
        idle(1); chk("R3 rising flag", irq, 1'b1);
        exp_val = 16'h0100;
        bus_rd(2'd0, d, dv); chk("R2 R11 sc flag", d, 8'hC4);
        bus_wr(2'd0, 8'h44);
        chk("R8 cleared", irq, 1'b0);
        cnt = 16'h0200; pin_in = 1'b0;
        idle(4); chk("R3 falling ignored", irq, 1'b0);
        bus_rd(2'd1, d, dv); chk("R3 value hi kept", d, exp_val[15:8]);
        bus_rd(2'd2, d, dv); chk("R3 value lo kept", d, exp_val[7:0]);

        // R3 random edge selection
        for (int i = 0; i < 20; i++) begin
            els = 2'($urandom_range(0, 3));
            cnt = 16'($urandom);
            bus_wr(2'd0, {4'b0100, els, 2'b00});
            rising = ~pin_in;
            pin_in = ~pin_in;
            idle(3);
            hit = cap_hit(els, rising);
            if (hit) exp_val = cnt;
            chk("R3 random flag", irq, hit);
            bus_rd(2'd1, d, dv); chk("R3 random hi", d, exp_val[15:8]);
            bus_rd(2'd2, d, dv); chk("R3 random lo", d, exp_val[7:0]);
            clear_flag({4'b0100, els, 2'b00});
        end

        // R4 directed compare, set action
        cnt = 16'h0000;
        bus_wr(2'd1, 8'h12); bus_wr(2'd2, 8'h34);
        bus_wr(2'd0, 8'h5C);
        chk("R13 compare oe", pin_oe, 1'b1);
        chk("R4 pin before", pin_out, 1'b0);
        cnt = 16'h1234; idle(1);
        chk("R4 set pin", pin_out, 1'b1);
        chk("R4 flag", irq, 1'b1);
        clear_flag(8'h5C);
        idle(2); chk("R4 held counter single event", irq, 1'b0);
        exp_pin = 1'b1;
        exp_val = 16'h1234;

        // R4 random compare actions
        for (int i = 0; i < 24; i++) begin
            els = 2'($urandom_range(1, 3));
            nv = 16'($urandom);
            if (~nv == exp_val) nv = nv ^ 16'h0001;
            cnt = ~nv;
            bus_wr(2'd0, {4'b0101, els, 2'b00});
            bus_wr(2'd1, nv[15:8]); bus_wr(2'd2, nv[7:0]);
            exp_val = nv;
            chk("R4 no early event", irq, 1'b0);
            cnt = nv; idle(1);
            exp_pin = oc_pin(els, exp_pin);
            chk("R4 random pin", pin_out, exp_pin);
            chk("R4 random flag", irq, 1'b1);
            cnt = ~nv;
            clear_flag({4'b0101, els, 2'b00});
        end

        // R5 overflow toggle and match priority
        bus_wr(2'd0, 8'h56);
        ovf = 1'b1; idle(1); ovf = 1'b0;
        exp_pin = ~exp_pin;
        chk("R5 ovf toggle", pin_out, exp_pin);
        cnt = exp_val; ovf = 1'b1; idle(1); ovf = 1'b0; cnt = ~exp_val;
        exp_pin = ~exp_pin;
        chk("R5 match wins over ovf", pin_out, exp_pin);
        clear_flag(8'h56);

        // R6 PWM high-true and inverted
        cnt = 16'hFFFF;
        bus_wr(2'd1, 8'h00); bus_wr(2'd2, 8'h80);
        bus_wr(2'd0, 8'h68);
        ovf = 1'b1; idle(1); ovf = 1'b0;
        chk("R6 ovf high", pin_out, 1'b1);
        hit_value(16'hFFFF, 16'h0080);
        chk("R6 match low", pin_out, 1'b0);
        chk("R6 pwm flag", irq, 1'b1);
        clear_flag(8'h68);
        bus_wr(2'd0, 8'h64);
        ovf = 1'b1; idle(1); ovf = 1'b0;
        chk("R6 inverted ovf low", pin_out, 1'b0);
        hit_value(16'hFFFF, 16'h0080);
        chk("R6 inverted match high", pin_out, 1'b1);
        clear_flag(8'h64);
        bus_wr(2'd0, 8'h68);
        ovf = 1'b1; idle(1); ovf = 1'b0;
        chk("R6 zero duty prep", pin_out, 1'b1);
        cnt = 16'h0080; ovf = 1'b1; idle(1); ovf = 1'b0; cnt = 16'hFFFF;
        chk("R6 zero duty", pin_out, 1'b0);
        clear_flag(8'h68);

        // R7 max duty
        bus_wr(2'd0, 8'h69);
        idle(1); chk("R7 forced high", pin_out, 1'b1);
        hit_value(16'hFFFF, 16'h0080);
        chk("R7 match ignored", pin_out, 1'b1);
        chk("R7 flag still sets", irq, 1'b1);
        clear_flag(8'h69);
        bus_wr(2'd0, 8'h65);
        idle(1); chk("R7 inverted forced low", pin_out, 1'b0);
        hit_value(16'hFFFF, 16'h0080);
        chk("R7 inverted match ignored", pin_out, 1'b0);
        clear_flag(8'h65);

        // R8 / R9 / R10 / R11 clear handshake
        bus_wr(2'd0, 8'h50);
        chk("R13 disconnected oe", pin_oe, 1'b0);
        hit_value(16'hFFFF, 16'h0080);
        chk("R13 flag without pin", irq, 1'b1);
        bus_rd(2'd0, d, dv); chk("R8 read flag", d, 8'hD0);
        hit_value(16'hFFFF, 16'h0080);
        bus_wr(2'd0, 8'h50);
        chk("R9 event between read and write", irq, 1'b1);
        clear_flag(8'h50);
        chk("R8 proper clear", irq, 1'b0);
        hit_value(16'hFFFF, 16'h0080);
        bus_wr(2'd0, 8'h50);
        chk("R8 write without read", irq, 1'b1);
        bus_rd(2'd0, d, dv);
        cnt = 16'hFFFF; idle(1);
        cnt = 16'h0080; addr = 2'd0; wdata = 8'h50; wr_en = 1'b1;
        idle(1); wr_en = 1'b0; cnt = 16'hFFFF;
        chk("R9 event same cycle as write", irq, 1'b1);
        clear_flag(8'h50);
        bus_wr(2'd0, 8'hD0);
        chk("R10 write one irq", irq, 1'b0);
        bus_rd(2'd0, d, dv); chk("R10 write one sc", d, 8'h50);
        hit_value(16'hFFFF, 16'h0080);
        bus_wr(2'd0, 8'h10);
        chk("R11 masked", irq, 1'b0);
        bus_wr(2'd0, 8'h50);
        chk("R11 unmasked", irq, 1'b1);
        bus_rd(2'd0, d, dv); chk("R11 flag kept", d, 8'hD0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule